// File: doc/BRIEF.md
# Zero-Overhead Instruction Block Repeater

This block sits next to the fetch stage of a multi-threaded core. It makes a block of 1 to 64 instructions that follows a repeat-start instruction run a set number of times, or without end, with no lost fetch slot between passes. Any thread may start it. From then on that thread owns it. The block watches that thread's fetch program counter. When the thread fetches the block's last instruction and passes remain, the block sends a redirect back to the block's first instruction. That redirect is registered and valid in the next cycle, so the fetch unit uses it for the thread's next fetch.

A start strobe carries the following fields:
- the PC of the start instruction
- the issue form
- the owning thread
- the block length, coded as length minus one
- the pass count, coded as count minus one
- an endless-repeat flag

Decode turns a register count of all ones into that endless flag. The two issue forms need different gaps before the block. The late form acts deep in the pipeline and leaves three slots. The early form acts two stages sooner and leaves one slot. The block computes the first-instruction address from the form. A branch taken by the owning thread cancels the repeat. A fresh start replaces whatever repeat is running.

Top module: `rep_block_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `redir_valid_o` is 0.
- R2: The block's first address is `start_pc_i + 4` when `start_early_i` is 0 (late form, three spacer slots). It is `start_pc_i + 2` when `start_early_i` is 1 (early form, one spacer slot). Every redirect carries this address on `redir_pc_o`.
- R3: The last address is the first address plus `start_len_i`, where the field holds length minus one (0 to 63). In the cycle after the owning thread fetches the last address with passes remaining, `redir_valid_o` is 1 and `redir_tid_o` names the owner. A thread that fetches every cycle therefore sees no gap between passes.
- R4: `start_cnt_i` holds pass count minus one in 14 bits. The block is fetched `start_cnt_i + 1` times in total, from 1 up to 16384.
- R5: With `start_inf_i` at 1, the block repeats regardless of `start_cnt_i` until it is cancelled.
- R6: On the final pass, the fetch of the last address gets no redirect and the repeater goes idle. A later fetch of that address gets no redirect.
- R7: A `branch_i` from the owning thread cancels the repeat. A fetch of the last address in that same cycle, or in any later cycle, gets no redirect.
- R8: Fetches and branches from threads other than the owner do not change the repeat.
- R9: A start strobe while a repeat is active replaces it. The old block's last address no longer gets a redirect.
- R10: A fetch with `fetch_valid_i` at 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Repeat start strobe |
| start_early_i | input | 1 | 1: early form (one spacer), 0: late form (three spacers) |
| start_tid_i | input | TID_W | Thread that issues the start and becomes owner |
| start_pc_i | input | PC_W | PC of the start instruction |
| start_len_i | input | LEN_W | Block length minus one |
| start_cnt_i | input | CNT_W | Pass count minus one |
| start_inf_i | input | 1 | Repeat without end |
| fetch_valid_i | input | 1 | A fetch takes place this cycle |
| fetch_tid_i | input | TID_W | Thread of this fetch |
| fetch_pc_i | input | PC_W | Address fetched |
| branch_i | input | 1 | A branch executed this cycle |
| branch_tid_i | input | TID_W | Thread of that branch |
| redir_valid_o | output | 1 | Redirect the named thread's next fetch |
| redir_tid_o | output | TID_W | Thread to redirect |
| redir_pc_o | output | PC_W | Target: first instruction of the block |

## Verification
The hardest states to reach are the two ends of the counter range: a 1-instruction block run 16384 times, and an endless repeat that has to be stopped. The bench reaches both with a fetch model. Each cycle the model either follows the last redirect or steps the PC by one. That keeps the fetch stream closed-loop, so the bench counts passes and total fetch slots instead of scripting them. A wrong count or a single bubble then shows up as a wrong total. Cancellation is placed exactly on the fetch of a chosen pass's last instruction, so the branch and the pending redirect collide in one cycle.

// File: rtl/rep_seq_pkg.sv
package rep_seq_pkg;
  localparam int unsigned LATE_SPACERS  = 3;
  localparam int unsigned EARLY_SPACERS = 1;

  typedef enum logic {
    ISSUE_LATE  = 1'b0,
    ISSUE_EARLY = 1'b1
  } issue_e;
endpackage

// File: rtl/rep_span_calc.sv
module rep_span_calc
  import rep_seq_pkg::*;
#(
  parameter int PC_W  = 9,
  parameter int LEN_W = 6
) (
  input  logic             early_i,
  input  logic [PC_W-1:0]  issue_pc_i,
  input  logic [LEN_W-1:0] len_m1_i,
  output logic [PC_W-1:0]  first_pc_o,
  output logic [PC_W-1:0]  last_pc_o
);
  localparam logic [PC_W-1:0] GAP_LATE  = PC_W'(LATE_SPACERS + 1);
  localparam logic [PC_W-1:0] GAP_EARLY = PC_W'(EARLY_SPACERS + 1);

  issue_e form;

  always_comb begin
    form       = issue_e'(early_i);
    first_pc_o = issue_pc_i + ((form == ISSUE_EARLY) ? GAP_EARLY : GAP_LATE);
    last_pc_o  = first_pc_o + PC_W'(len_m1_i);
  end
endmodule

// File: rtl/rep_iter_ctr.sv
module rep_iter_ctr #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)         left_q <= '0;
    else if (load_i) left_q <= load_val_i;
    else if (dec_i)  left_q <= left_q - 1'b1;
  end

  assign last_o = (left_q == '0);

  // R4: the pass counter is never stepped below zero
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !load_i) |-> (left_q != '0));
endmodule

// File: rtl/rep_block_seq.sv
module rep_block_seq #(
  parameter int THREADS = 4,
  parameter int PC_W    = 9,
  parameter int LEN_W   = 6,
  parameter int CNT_W   = 14,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             start_early_i,
  input  logic [TID_W-1:0] start_tid_i,
  input  logic [PC_W-1:0]  start_pc_i,
  input  logic [LEN_W-1:0] start_len_i,
  input  logic [CNT_W-1:0] start_cnt_i,
  input  logic             start_inf_i,
  input  logic             fetch_valid_i,
  input  logic [TID_W-1:0] fetch_tid_i,
  input  logic [PC_W-1:0]  fetch_pc_i,
  input  logic             branch_i,
  input  logic [TID_W-1:0] branch_tid_i,
  output logic             redir_valid_o,
  output logic [TID_W-1:0] redir_tid_o,
  output logic [PC_W-1:0]  redir_pc_o
);
  logic             active_q, inf_q;
  logic [TID_W-1:0] owner_q;
  logic [PC_W-1:0]  first_q, last_q;
  logic [PC_W-1:0]  span_first, span_last;
  logic             ctr_last;
  logic             own_fetch, at_end, own_branch, more, take;

  rep_span_calc #(.PC_W(PC_W), .LEN_W(LEN_W)) u_span (
    .early_i    (start_early_i),
    .issue_pc_i (start_pc_i),
    .len_m1_i   (start_len_i),
    .first_pc_o (span_first),
    .last_pc_o  (span_last)
  );

  always_comb begin
    own_fetch  = active_q && fetch_valid_i && (fetch_tid_i == owner_q);
    at_end     = own_fetch && (fetch_pc_i == last_q);
    own_branch = active_q && branch_i && (branch_tid_i == owner_q);
    more       = inf_q || !ctr_last;
    take       = at_end && more && !own_branch && !start_i;
  end

  rep_iter_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (start_i),
    .load_val_i (start_cnt_i),
    .dec_i      (take && !inf_q),
    .last_o     (ctr_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      inf_q    <= 1'b0;
      owner_q  <= '0;
      first_q  <= '0;
      last_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      inf_q    <= start_inf_i;
      owner_q  <= start_tid_i;
      first_q  <= span_first;
      last_q   <= span_last;
    end else if (own_branch || (at_end && !more)) begin
      active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid_o <= 1'b0;
      redir_tid_o   <= '0;
      redir_pc_o    <= '0;
    end else begin
      redir_valid_o <= take;
      redir_tid_o   <= owner_q;
      redir_pc_o    <= first_q;
    end
  end

  // R1: reset leaves no redirect pending
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    rst |=> !redir_valid_o);

  // R3: a redirect always follows the owner's fetch of the last address
  assert_redir_after_end_R3: assert property (@(posedge clk) disable iff (rst)
    redir_valid_o |-> ($past(fetch_valid_i) && ($past(fetch_tid_i) == redir_tid_o)
                       && ($past(fetch_pc_i) == last_q)));

  // R7: an owner branch is never followed by a redirect
  assert_branch_cancels_R7: assert property (@(posedge clk) disable iff (rst)
    (branch_i && active_q && (branch_tid_i == owner_q)) |=> !redir_valid_o);

  // R10: an invalid fetch cycle never produces a redirect
  assert_idle_fetch_R10: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid_i |=> !redir_valid_o);
endmodule

// File: tb/rep_block_seq_test.sv
module rep_block_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 9, LEN_W = 6, CNT_W = 14, TID_W = 2;
  localparam int NVEC = 6;
  // {early, len-1, count-1, endless}
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b0, 6'd0,  14'd0,     1'b0},
    {1'b0, 6'd3,  14'd4,     1'b0},
    {1'b1, 6'd2,  14'd2,     1'b0},
    {1'b1, 6'd0,  14'd6,     1'b0},
    {1'b0, 6'd63, 14'd1,     1'b0},
    {1'b1, 6'd0,  14'd16383, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 0, start_early_i = 0, start_inf_i = 0;
  logic [TID_W-1:0] start_tid_i = '0, fetch_tid_i = '0, branch_tid_i = '0;
  logic [PC_W-1:0]  start_pc_i = '0, fetch_pc_i = '0;
  logic [LEN_W-1:0] start_len_i = '0;
  logic [CNT_W-1:0] start_cnt_i = '0;
  logic fetch_valid_i = 0, branch_i = 0;
  logic redir_valid_o;
  logic [TID_W-1:0] redir_tid_o;
  logic [PC_W-1:0]  redir_pc_o;

  int total = 0, bad = 0;

  rep_block_seq uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit st, input bit fv, input logic [TID_W-1:0] ft,
                      input logic [PC_W-1:0] fp, input bit br, input logic [TID_W-1:0] bt);
    @(negedge clk);
    start_i = st; fetch_valid_i = fv; fetch_tid_i = ft; fetch_pc_i = fp;
    branch_i = br; branch_tid_i = bt;
    @(posedge clk); #1;
  endtask

  task automatic arm(input bit early, input logic [TID_W-1:0] tid, input logic [PC_W-1:0] pc,
                     input logic [LEN_W-1:0] lm1, input logic [CNT_W-1:0] cm1, input bit inf);
    start_early_i = early; start_tid_i = tid; start_pc_i = pc;
    start_len_i = lm1; start_cnt_i = cm1; start_inf_i = inf;
  endtask

  // closed-loop fetch model of one thread running a repeat
  task automatic run_block(input bit early, input logic [LEN_W-1:0] lm1,
                           input logic [CNT_W-1:0] cm1, input bit inf, input int brk,
                           input logic [TID_W-1:0] tid, input logic [PC_W-1:0] p,
                           output int hits, output int badpc, output int slots,
                           output logic [PC_W-1:0] last);
    logic [PC_W-1:0] first, pc, nxt;
    bit br;
    first = p + 9'd1 + (early ? 9'd1 : 9'd3);
    last  = first + PC_W'(lm1);
    hits = 0; badpc = 0; slots = 0;
    arm(early, tid, p, lm1, cm1, inf);
    step(1, 1, tid, p, 0, tid);
    pc = p;
    for (int c = 0; c < 20000; c++) begin
      if (redir_valid_o) begin
        if (redir_pc_o !== first || redir_tid_o !== tid) badpc++;
        nxt = redir_pc_o;
      end else begin
        if (pc == last) break;
        nxt = pc + 1'b1;
      end
      pc = nxt;
      br = 0;
      if (pc == last) begin
        hits++;
        br = (brk > 0) && (hits == brk);
      end
      slots++;
      step(0, 1, tid, pc, br, tid);
    end
    step(0, 0, tid, '0, 0, tid);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hits, badpc, slots;
    logic [PC_W-1:0] last;
    repeat (3) @(posedge clk);
    #1;
    chk(redir_valid_o == 0, "R1 during reset", redir_valid_o, 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    chk(redir_valid_o == 0, "R1 after reset", redir_valid_o, 0);

    // table walk: pass count, target address, gap-free timing, fall-through
    for (int i = 0; i < NVEC; i++) begin
      logic e; logic [LEN_W-1:0] l; logic [CNT_W-1:0] c; logic f;
      int gap;
      {e, l, c, f} = VEC[i];
      gap = e ? 1 : 3;
      run_block(e, l, c, f, 0, 2'd0, 9'd20, hits, badpc, slots, last);
      chk(hits == int'(c) + 1, "R4 pass count", hits, int'(c) + 1);
      chk(badpc == 0, "R2 redirect target", badpc, 0);
      chk(slots == gap + (int'(c) + 1) * (int'(l) + 1), "R3 no bubble",
          slots, gap + (int'(c) + 1) * (int'(l) + 1));
      step(0, 1, 2'd0, last, 0, 2'd0);
      chk(redir_valid_o == 0, "R6 idle after last pass", redir_valid_o, 0);
    end

    // R5: endless repeat stopped by a branch on the 20th pass
    run_block(1'b0, 6'd2, 14'd0, 1'b1, 20, 2'd3, 9'd40, hits, badpc, slots, last);
    chk(hits == 20, "R5 endless repeat", hits, 20);

    // R7: finite repeat cancelled by an owner branch on pass 3 of 10
    run_block(1'b1, 6'd2, 14'd9, 1'b0, 3, 2'd0, 9'd60, hits, badpc, slots, last);
    chk(hits == 3, "R7 branch cancel", hits, 3);
    step(0, 1, 2'd0, last, 0, 2'd0);
    chk(redir_valid_o == 0, "R7 stays cancelled", redir_valid_o, 0);

    // R10: invalid fetch of the last address is ignored
    arm(1'b0, 2'd0, 9'd100, 6'd0, 14'd3, 1'b0);
    step(1, 0, 2'd0, 9'd0, 0, 2'd0);
    step(0, 0, 2'd0, 9'd104, 0, 2'd0);
    chk(redir_valid_o == 0, "R10 invalid fetch", redir_valid_o, 0);
    step(0, 1, 2'd0, 9'd104, 0, 2'd0);
    chk(redir_valid_o == 1 && redir_pc_o == 9'd104, "R10 valid fetch redirects",
        redir_pc_o, 104);

    // R8: other threads neither trigger nor cancel
    arm(1'b1, 2'd1, 9'd200, 6'd1, 14'd5, 1'b0);
    step(1, 0, 2'd0, 9'd0, 0, 2'd0);
    step(0, 1, 2'd0, 9'd203, 0, 2'd0);
    chk(redir_valid_o == 0, "R8 other thread fetch", redir_valid_o, 0);
    step(0, 0, 2'd0, 9'd0, 1, 2'd2);
    step(0, 1, 2'd1, 9'd203, 0, 2'd0);
    chk(redir_valid_o == 1 && redir_tid_o == 2'd1 && redir_pc_o == 9'd202,
        "R8 owner still repeats", redir_pc_o, 202);

    // R9: restart replaces the running repeat
    arm(1'b1, 2'd1, 9'd300, 6'd0, 14'd2, 1'b0);
    step(1, 0, 2'd0, 9'd0, 0, 2'd0);
    step(0, 1, 2'd1, 9'd203, 0, 2'd0);
    chk(redir_valid_o == 0, "R9 old block dropped", redir_valid_o, 0);
    step(0, 1, 2'd1, 9'd302, 0, 2'd0);
    chk(redir_valid_o == 1 && redir_pc_o == 9'd302, "R9 new block", redir_pc_o, 302);
    step(0, 0, 2'd0, 9'd0, 0, 2'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule